// File: doc/BRIEF.md
# Wide-Aspect Vertical Scan Controller

This block sits beside the vertical timing of a 4:3 delta-pixel panel driver and lets that panel show a letterboxed, quasi-16:9 picture. Once per line it decides how the vertical scanner should treat the coming line. It also decides which line-rate control pulses go out on that line. When the wide-aspect enable is low, every line gets ordinary 4:3 treatment.

With the enable high, a field is split into three bands. The first is a black band at the top of the panel. Next comes a display band, in which some lines are dropped from vertical scanning so that the picture is squeezed vertically. The last is a black band at the bottom. In the black bands, lines are taken in pairs: the first line of a pair is driven at normal speed and the second at four times that speed.

In the black bands the block also does the following:
- It halves the rate of the horizontal start pulse and of the AC-drive polarity toggle.
- It blocks the enable and clear pulses.
- It raises a black-insertion flag, which a downstream RGB driver uses to force black.

The block does not shape the vertical clock waveform and does not touch the video itself. It only issues one control word per line.

A `line_stb` pulse marks the start of each line. A `field_stb` pulse marks line 0 of a field. All outputs are registered and change only in the clock after one of these strobes.

Top module: `wide_vscan_ctl`

## Requirements
- R1: When `wide_en` is low at a strobe, the next control word is the normal one: `vck_skip`=0, `vck_quad`=0, `hst_en`=1, `frp_toggle`=1, `en_ok`=1, `clr_ok`=1, `sblk`=0.
- R2: Line numbers count from 0 at `field_stb`, and each later `line_stb` adds 1. With `panel_sel`=0 the bands are: top black on lines 0–27, display on lines 28–190, bottom black on lines 191–217. With `panel_sel`=1 the bands are: top black on lines 0–27, display on lines 28–196, bottom black on lines 197–224. Lines after the bottom band get the normal word.
- R3: On every line of either black band, with `wide_en` high, `sblk`=1, `en_ok`=0, `clr_ok`=0 and `vck_skip`=0.
- R4: Inside a black band, let the offset be the line number minus the first line of that band. When the offset is even, the line is driven at normal speed: `vck_quad`=0, `hst_en`=1, `frp_toggle`=1. When the offset is odd, the line is driven at quadruple speed: `vck_quad`=1, `hst_en`=0, `frp_toggle`=0. As a result, HST repeats every 2 lines and the polarity holds for 2 lines, so it repeats every 4 lines.
- R5: In the display band with `pal_sel`=0, let k be the line number minus 28. `vck_skip`=1 exactly when k mod 4 = 3. All other outputs stay at their normal values.
- R6: In the display band with `pal_sel`=1, the dropping alternates between one line out of 2 and one line out of 4. `vck_skip`=1 exactly when k mod 6 is 1 or 5.
- R7: `field_stb` restarts the line count and the drop sequence at line 0. If `field_stb` and `line_stb` arrive in the same cycle, `field_stb` wins.
- R8: The control word changes only in the clock that follows a strobe. Input changes between strobes have no effect until the next strobe.
- R9: From reset until the first `field_stb`, every line gets the normal word, whatever `wide_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle pulse at each line start |
| field_stb | input | 1 | One-cycle pulse at line 0 of a field |
| pal_sel | input | 1 | 1 selects the PAL drop pattern, 0 selects NTSC |
| panel_sel | input | 1 | 0 selects the small panel, 1 selects the large panel |
| wide_en | input | 1 | Enables wide-aspect conversion |
| vck_skip | output | 1 | Drop this line from vertical scanning |
| vck_quad | output | 1 | Drive this line at quadruple vertical speed |
| hst_en | output | 1 | Issue the horizontal start pulse on this line |
| frp_toggle | output | 1 | Toggle the AC-drive polarity at this line |
| en_ok | output | 1 | Enable pulse permitted on this line |
| clr_ok | output | 1 | Clear pulse permitted on this line |
| sblk | output | 1 | Black-insertion flag |

## Verification
The bench sweeps whole fields for every combination of panel, standard and enable, and predicts each line's word from band arithmetic.

It targets the band edges at lines 27/28 and 190/191 (196/197 on the large panel). If a band ended one line early or late, the black flag would show up on a display line, or vanish from a black one.

The bottom band begins on an odd line number. A design that derived the pair phase from the raw line number instead of the band offset would therefore invert normal and quadruple lines there.

Three further cases are covered:
- A field restart in the middle of the display band, and a field strobe coinciding with a line strobe. A sequence that failed to restart would drop the wrong lines in the next field.
- Flipping the enable between strobes. A design that decoded outputs combinationally would leak that change straight to the outputs.
- Lines sent before any field start. These must stay normal.

// File: rtl/wvs_pkg.sv
`timescale 1ns/1ps
package wvs_pkg;

   typedef enum logic [1:0] {
      RG_TOP  = 2'd0,
      RG_DISP = 2'd1,
      RG_BOT  = 2'd2,
      RG_OUT  = 2'd3
   } wvs_region_e;

   typedef struct packed {
      logic skip;
      logic quad;
      logic hst_en;
      logic frp_tgl;
      logic en_ok;
      logic clr_ok;
      logic sblk;
   } wvs_ctl_t;

   localparam wvs_ctl_t CTL_NORMAL = '{skip: 1'b0, quad: 1'b0, hst_en: 1'b1,
                                       frp_tgl: 1'b1, en_ok: 1'b1, clr_ok: 1'b1,
                                       sblk: 1'b0};

endpackage

// File: rtl/wvs_region_map.sv
`timescale 1ns/1ps
module wvs_region_map
   import wvs_pkg::*;
#(
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned TOP_LINES = 28,
   parameter int unsigned DISP_S    = 163,
   parameter int unsigned DISP_L    = 169,
   parameter int unsigned BOT_S     = 27,
   parameter int unsigned BOT_L     = 28
) (
   input  logic [LINE_W-1:0] line_idx,
   input  logic              panel_sel,
   output wvs_region_e       region,
   output logic              pair_odd
);

   localparam int unsigned DEND_S = TOP_LINES + DISP_S;
   localparam int unsigned DEND_L = TOP_LINES + DISP_L;
   localparam int unsigned BEND_S = DEND_S + BOT_S;
   localparam int unsigned BEND_L = DEND_L + BOT_L;

   if (BEND_L >= (1 << LINE_W) - 1 || BEND_S >= (1 << LINE_W) - 1) begin : g_bad_width
      $error("wvs_region_map: LINE_W too small for the band layout");
   end

   logic [LINE_W-1:0] disp_end;
   logic [LINE_W-1:0] bot_end;
   logic [LINE_W-1:0] bot_off;

   always_comb begin
      disp_end = panel_sel ? LINE_W'(DEND_L) : LINE_W'(DEND_S);
      bot_end  = panel_sel ? LINE_W'(BEND_L) : LINE_W'(BEND_S);
      bot_off  = line_idx - disp_end;
      if (line_idx < LINE_W'(TOP_LINES)) begin
         region   = RG_TOP;
         pair_odd = line_idx[0];
      end else if (line_idx < disp_end) begin
         region   = RG_DISP;
         pair_odd = 1'b0;
      end else if (line_idx < bot_end) begin
         region   = RG_BOT;
         pair_odd = bot_off[0];
      end else begin
         region   = RG_OUT;
         pair_odd = 1'b0;
      end
   end

endmodule

// File: rtl/wvs_skip_seq.sv
`timescale 1ns/1ps
module wvs_skip_seq #(
   parameter int unsigned NTSC_GROUP = 4,
   parameter int unsigned PAL_SHORT  = 2,
   parameter int unsigned PAL_LONG   = 4,
   parameter bit          PAL_MIX    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic restart,
   input  logic disp_next,
   input  logic pal_sel,
   output logic skip_next
);

   localparam int unsigned PAL_PERIOD = PAL_SHORT + PAL_LONG;
   localparam int unsigned MAX_PERIOD = (PAL_PERIOD > NTSC_GROUP) ? PAL_PERIOD : NTSC_GROUP;
   localparam int unsigned SEQ_W      = $clog2(MAX_PERIOD + 1);

   if (NTSC_GROUP < 2 || PAL_SHORT < 2 || PAL_LONG < 2) begin : g_bad_group
      $error("wvs_skip_seq: every drop group needs at least two lines");
   end

   logic [SEQ_W-1:0] pos_q;
   logic [SEQ_W-1:0] pos_next;
   logic [SEQ_W-1:0] last_pos;
   logic             in_disp_q;
   logic             pal_hit;
   logic             ntsc_hit;

   assign last_pos = (pal_sel && PAL_MIX) ? SEQ_W'(PAL_PERIOD - 1) : SEQ_W'(NTSC_GROUP - 1);

   always_comb begin
      if (restart || !in_disp_q || pos_q >= last_pos) pos_next = '0;
      else                                            pos_next = pos_q + 1'b1;
   end

   assign ntsc_hit = (pos_next == SEQ_W'(NTSC_GROUP - 1));

   if (PAL_MIX) begin : g_pal_mix
      assign pal_hit = (pos_next == SEQ_W'(PAL_SHORT - 1)) ||
                       (pos_next == SEQ_W'(PAL_PERIOD - 1));
   end else begin : g_pal_plain
      assign pal_hit = ntsc_hit;
   end

   assign skip_next = disp_next && (pal_sel ? pal_hit : ntsc_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         in_disp_q <= 1'b0;
      end else if (evt) begin
         pos_q     <= disp_next ? pos_next : '0;
         in_disp_q <= disp_next;
      end
   end

   // R5
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < SEQ_W'(MAX_PERIOD));

   // R7
   restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt && restart) |-> pos_q == '0);

endmodule

// File: rtl/wide_vscan_ctl.sv
`timescale 1ns/1ps
module wide_vscan_ctl
   import wvs_pkg::*;
#(
   parameter int unsigned LINE_W     = 10,
   parameter int unsigned TOP_LINES  = 28,
   parameter int unsigned DISP_S     = 163,
   parameter int unsigned DISP_L     = 169,
   parameter int unsigned BOT_S      = 27,
   parameter int unsigned BOT_L      = 28,
   parameter int unsigned NTSC_GROUP = 4,
   parameter int unsigned PAL_SHORT  = 2,
   parameter int unsigned PAL_LONG   = 4,
   parameter bit          PAL_MIX    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_stb,
   input  logic field_stb,
   input  logic pal_sel,
   input  logic panel_sel,
   input  logic wide_en,
   output logic vck_skip,
   output logic vck_quad,
   output logic hst_en,
   output logic frp_toggle,
   output logic en_ok,
   output logic clr_ok,
   output logic sblk
);

   localparam logic [LINE_W-1:0] IDX_IDLE = '1;

   if (TOP_LINES < 2) begin : g_bad_top
      $error("wide_vscan_ctl: top band must hold at least one line pair");
   end

   logic [LINE_W-1:0] idx_q;
   logic [LINE_W-1:0] idx_next;
   logic              evt;
   wvs_region_e       reg_next;
   logic              odd_next;
   logic              skip_next;
   wvs_ctl_t          ctl_next;
   wvs_ctl_t          ctl_q;

   assign evt = field_stb | line_stb;

   always_comb begin
      if (field_stb)              idx_next = '0;
      else if (idx_q == IDX_IDLE) idx_next = idx_q;
      else                        idx_next = idx_q + 1'b1;
   end

   wvs_region_map #(
      .LINE_W   (LINE_W),
      .TOP_LINES(TOP_LINES),
      .DISP_S   (DISP_S),
      .DISP_L   (DISP_L),
      .BOT_S    (BOT_S),
      .BOT_L    (BOT_L)
   ) u_map (
      .line_idx (idx_next),
      .panel_sel(panel_sel),
      .region   (reg_next),
      .pair_odd (odd_next)
   );

   wvs_skip_seq #(
      .NTSC_GROUP(NTSC_GROUP),
      .PAL_SHORT (PAL_SHORT),
      .PAL_LONG  (PAL_LONG),
      .PAL_MIX   (PAL_MIX)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .restart  (field_stb),
      .disp_next(wide_en && reg_next == RG_DISP),
      .pal_sel  (pal_sel),
      .skip_next(skip_next)
   );

   always_comb begin
      ctl_next = CTL_NORMAL;
      if (wide_en) begin
         unique case (reg_next)
            RG_TOP, RG_BOT: begin
               ctl_next.sblk    = 1'b1;
               ctl_next.en_ok   = 1'b0;
               ctl_next.clr_ok  = 1'b0;
               ctl_next.quad    = odd_next;
               ctl_next.hst_en  = !odd_next;
               ctl_next.frp_tgl = !odd_next;
            end
            RG_DISP: ctl_next.skip = skip_next;
            default: ctl_next = CTL_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= IDX_IDLE;
         ctl_q <= CTL_NORMAL;
      end else if (evt) begin
         idx_q <= idx_next;
         ctl_q <= ctl_next;
      end
   end

   assign vck_skip   = ctl_q.skip;
   assign vck_quad   = ctl_q.quad;
   assign hst_en     = ctl_q.hst_en;
   assign frp_toggle = ctl_q.frp_tgl;
   assign en_ok      = ctl_q.en_ok;
   assign clr_ok     = ctl_q.clr_ok;
   assign sblk       = ctl_q.sblk;

   // R3
   black_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sblk |-> (!en_ok && !clr_ok && !vck_skip));

   // R4
   quad_in_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vck_quad |-> (sblk && !hst_en && !frp_toggle));

   // R4
   pair_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt) && $past(vck_quad) && sblk) |-> !vck_quad);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(evt) |-> $stable(ctl_q));

   // R1
   narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt) && !$past(wide_en)) |-> (ctl_q == CTL_NORMAL));

endmodule

// File: tb/wide_vscan_ctl_bench.sv
`timescale 1ns/1ps
module wide_vscan_ctl_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_stb = 1'b0;
   logic field_stb = 1'b0;
   logic pal_sel = 1'b0;
   logic panel_sel = 1'b0;
   logic wide_en = 1'b0;
   logic vck_skip, vck_quad, hst_en, frp_toggle, en_ok, clr_ok, sblk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int line_no = -1;

   localparam logic [6:0] NORM = 7'b0011110;

   always #2 clk = ~clk;

   wide_vscan_ctl u_wide_vscan_ctl (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
      .pal_sel(pal_sel), .panel_sel(panel_sel), .wide_en(wide_en),
      .vck_skip(vck_skip), .vck_quad(vck_quad), .hst_en(hst_en),
      .frp_toggle(frp_toggle), .en_ok(en_ok), .clr_ok(clr_ok), .sblk(sblk)
   );

   function automatic logic [6:0] outs();
      return {vck_skip, vck_quad, hst_en, frp_toggle, en_ok, clr_ok, sblk};
   endfunction

   // R2: band arithmetic
   function automatic logic [6:0] model(int n, bit pal, bit pan, bit wide);
      int dend, bend, k;
      dend = 28 + (pan ? 169 : 163);
      bend = dend + (pan ? 28 : 27);
      if (!wide || n < 0 || n >= bend) return NORM;
      if (n < 28 || n >= dend) begin
         k = (n < 28) ? n : n - dend;
         return (k % 2 == 0) ? 7'b0011001 : 7'b0100001;
      end
      k = n - 28;
      if (pal) return ((k % 6 == 1) || (k % 6 == 5)) ? 7'b1011110 : NORM;
      return (k % 4 == 3) ? 7'b1011110 : NORM;
   endfunction

   function automatic string tag_of(int n, bit pal, bit pan, bit wide);
      int dend, bend;
      dend = 28 + (pan ? 169 : 163);
      bend = dend + (pan ? 28 : 27);
      if (n < 0) return "R9";
      if (!wide) return "R1";
      if (n == 0) return "R7";
      if (n < 28 || (n >= dend && n < bend)) return "R3/R4";
      if (n >= bend) return "R2";
      return pal ? "R6" : "R5";
   endfunction

   task automatic check(logic [6:0] got, logic [6:0] exp, string tag);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s line %0d: got %b expected %b", tag, line_no, got, exp);
      end
   endtask

   task automatic step(bit f, bit l);
      logic [6:0] exp;
      @(negedge clk);
      field_stb = f;
      line_stb  = l;
      @(negedge clk);
      field_stb = 1'b0;
      line_stb  = 1'b0;
      if (f) line_no = 0;
      else if (line_no >= 0) line_no++;
      exp = model(line_no, pal_sel, panel_sel, wide_en);
      check(outs(), exp, tag_of(line_no, pal_sel, panel_sel, wide_en));
      // R8: input change between strobes must not reach the outputs
      wide_en = ~wide_en;
      @(negedge clk);
      check(outs(), exp, "R8");
      wide_en = ~wide_en;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(outs(), NORM, "R9");
      rst_n = 1'b1;
      wide_en = 1'b1;
      // R9: lines before any field start
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

      for (int cfg = 0; cfg < 8; cfg++) begin
         panel_sel = cfg[0];
         pal_sel   = cfg[1];
         wide_en   = cfg[2];
         step(1'b1, 1'b0);
         for (int i = 1; i < 232; i++) step(1'b0, 1'b1);
      end

      // R7: restart mid display band, PAL, then check drop sequence restarts
      wide_en = 1'b1; pal_sel = 1'b1; panel_sel = 1'b0;
      step(1'b1, 1'b0);
      for (int i = 1; i < 101; i++) step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      for (int i = 1; i < 70; i++) step(1'b0, 1'b1);
      // R7: coincident strobes, field wins
      pal_sel = 1'b0;
      step(1'b1, 1'b1);
      for (int i = 1; i < 50; i++) step(1'b0, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule